// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

This unit multiplies or divides two 32-bit operands, signed or unsigned, over many clock cycles. It uses a single add/subtract and shift datapath that retires one operand bit per cycle. In multiply mode the datapath runs as a shift-add multiplier. In divide mode it runs as a restoring divider.

The result lands in two 32-bit registers. For a multiply, the high register takes the upper half of the 64-bit product and the low register takes the lower half. For a divide, the high register takes the remainder and the low register takes the quotient. A caller reads the low half on its own for a truncated product. It compares the high half against the sign extension of the low half to detect that a product did not fit in 32 bits.

Signed operations run on operand magnitudes. A final fix-up cycle then negates whichever results need it. The unit performs no overflow check and no divide-by-zero check; software handles both.

Top module: `mdu_top`

## Requirements
- R1: After reset, busy_o and done_o are low and hi_o and lo_o are zero.
- R2: The operation select is 2 bits. op_i[0]=1 selects divide and 0 selects multiply. op_i[1]=1 selects signed and 0 selects unsigned. An unsigned multiply leaves the 64-bit product {hi_o, lo_o}.
- R3: A signed multiply leaves the two's-complement 64-bit product of the signed operands in {hi_o, lo_o}.
- R4: An unsigned divide leaves the quotient in lo_o and the remainder in hi_o.
- R5: A signed divide computes the quotient and remainder from the magnitudes of the operands. The quotient is negated when exactly one operand is negative. The remainder is negated when the dividend is negative.
- R6: A start is accepted on a rising edge where start_i is high and busy_o is low. busy_o is then high for the next 34 cycles. done_o is high for exactly one cycle, beginning 34 edges after the accepting edge, with busy_o low in that cycle.
- R7: start_i, op_i, a_i and b_i are ignored while busy_o is high. They cause no extra result, and they do not change the result of the operation in flight.
- R8: hi_o and lo_o change only in the cycle in which done_o is high. Until then they hold the previous result.
- R9: A zero divisor raises no error. The quotient magnitude becomes all ones and the remainder magnitude becomes the dividend magnitude. The R5 sign rules then apply, so an unsigned a/0 gives lo_o=FFFFFFFF and hi_o=a.
- R10: A start presented in the cycle where done_o is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation |
| op_i | input | 2 | Bit 0: divide; bit 1: signed |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result registers update |
| hi_o | output | 32 | Product upper half or remainder |
| lo_o | output | 32 | Product lower half or quotient |

## Verification
Two events can share a cycle: the completion of one operation, when done_o pulses and the result registers load, and the acceptance of the next start. The bench's driver waits only for busy_o to drop, so each queued operation is requested in the very cycle its predecessor reports done. The bench judges each such pair by three things: busy_o rises again on the following edge, the earlier result is still correct, and the new result appears exactly 34 edges after its own accepting edge.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIX   = 2'd3
  } mdu_state_e;

  // op_i encoding
  localparam int unsigned OP_DIV_BIT = 0;
  localparam int unsigned OP_SGN_BIT = 1;
endpackage

// File: rtl/mdu_addsub.sv
module mdu_addsub #(
  parameter int unsigned N = 34
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic         sub_i,
  output logic [N-1:0] s_o
);
  logic [N-1:0] y_eff;
  assign y_eff = y_i ^ {N{sub_i}};
  assign s_o   = x_i + y_eff + N'(sub_i);
endmodule

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output mdu_state_e st_o,
  output logic       accept_o,
  output logic       done_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mdu_state_e st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign accept_o = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_SETUP;
      ST_SETUP: st_d = ST_ITER;
      ST_ITER:  if (cnt_q == LAST) st_d = ST_FIX;
      ST_FIX:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_FIX);
      if (st_q == ST_SETUP)     cnt_q <= '0;
      else if (st_q == ST_ITER) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign st_o   = st_q;
  assign done_o = done_q;

  assert_iter_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ITER && cnt_q == LAST) |=> (st_q == ST_FIX));
  assert_iter_stay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ITER && cnt_q != LAST) |=> (st_q == ST_ITER));
  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && start_i) |=> (st_q != ST_SETUP));
endmodule

// File: rtl/mdu_dp.sv
module mdu_dp
  import mdu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  mdu_state_e   st_i,
  input  logic         accept_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] fix_hi_o,
  output logic [W-1:0] fix_lo_o
);
  localparam int unsigned AW = W + 2;

  logic [W-1:0] a_q, b_q, d_q, up_q, lo_q;
  logic         div_q, sgn_q, neg_lo_q, neg_hi_q;

  logic         a_neg, b_neg;
  logic [W-1:0] mag_a, mag_b;
  logic [W:0]   rem_sh;
  logic [AW-1:0] add_x, add_y, sum;
  logic         went_neg;

  assign a_neg = sgn_q & a_q[W-1];
  assign b_neg = sgn_q & b_q[W-1];
  assign mag_a = a_neg ? (~a_q + 1'b1) : a_q;
  assign mag_b = b_neg ? (~b_q + 1'b1) : b_q;

  // divide: trial subtract of divisor from shifted partial remainder
  // multiply: conditional add of multiplicand into upper half
  assign rem_sh = {up_q, lo_q[W-1]};
  assign add_x  = div_q ? {1'b0, rem_sh} : {2'b00, up_q};
  assign add_y  = (div_q || lo_q[0]) ? {2'b00, d_q} : '0;

  mdu_addsub #(.N(AW)) u_addsub (
    .x_i   (add_x),
    .y_i   (add_y),
    .sub_i (div_q),
    .s_o   (sum)
  );

  assign went_neg = sum[AW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= '0;
      b_q      <= '0;
      d_q      <= '0;
      up_q     <= '0;
      lo_q     <= '0;
      div_q    <= 1'b0;
      sgn_q    <= 1'b0;
      neg_lo_q <= 1'b0;
      neg_hi_q <= 1'b0;
    end else begin
      unique case (st_i)
        ST_IDLE: if (accept_i) begin
          a_q   <= a_i;
          b_q   <= b_i;
          div_q <= op_i[OP_DIV_BIT];
          sgn_q <= op_i[OP_SGN_BIT];
        end
        ST_SETUP: begin
          d_q      <= mag_b;
          up_q     <= '0;
          lo_q     <= mag_a;
          neg_lo_q <= a_neg ^ b_neg;
          neg_hi_q <= div_q ? a_neg : (a_neg ^ b_neg);
        end
        ST_ITER: begin
          if (div_q) begin
            // restoring step: on a negative trial keep the unsubtracted value
            up_q <= went_neg ? rem_sh[W-1:0] : sum[W-1:0];
            lo_q <= {lo_q[W-2:0], ~went_neg};
          end else begin
            up_q <= sum[W:1];
            lo_q <= {sum[0], lo_q[W-1:1]};
          end
        end
        default: ;
      endcase
    end
  end

  logic [2*W-1:0] prod, prod_neg;
  assign prod     = {up_q, lo_q};
  assign prod_neg = ~prod + 1'b1;

  always_comb begin
    if (div_q) begin
      fix_hi_o = neg_hi_q ? (~up_q + 1'b1) : up_q;
      fix_lo_o = neg_lo_q ? (~lo_q + 1'b1) : lo_q;
    end else begin
      {fix_hi_o, fix_lo_o} = neg_lo_q ? prod_neg : prod;
    end
  end

  assert_rem_below_divisor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ITER && div_q && d_q != '0) |-> (up_q < d_q));
  assert_mul_lo_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_SETUP) |=> (up_q == '0));
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  mdu_state_e   st;
  logic         accept;
  logic [W-1:0] fix_hi, fix_lo;
  logic [W-1:0] hi_q, lo_q;

  mdu_ctrl #(.W(W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .st_o     (st),
    .accept_o (accept),
    .done_o   (done_o)
  );

  mdu_dp #(.W(W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .st_i     (st),
    .accept_i (accept),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .fix_hi_o (fix_hi),
    .fix_lo_o (fix_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (st == ST_FIX) begin
      hi_q <= fix_hi;
      lo_q <= fix_lo;
    end
  end

  assign busy_o = (st != ST_IDLE);
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  assert_done_not_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_follows_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));
  assert_back_to_back_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> busy_o);
endmodule

// File: tb/sim_mdu_top.sv
`timescale 1ns/1ps
module sim_mdu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [31:0] last_hi = '0, last_lo = '0;

  typedef struct {
    logic [31:0] hi;
    logic [31:0] lo;
    int          cyc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdu_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic void model(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                                output logic [31:0] rh, output logic [31:0] rl);
    logic [63:0] p;
    logic [31:0] mx, my, q, r;
    if (!o[0]) begin
      if (o[1]) p = 64'(longint'($signed(x)) * longint'($signed(y)));
      else      p = {32'b0, x} * {32'b0, y};
      rh = p[63:32];
      rl = p[31:0];
    end else begin
      mx = (o[1] && x[31]) ? -x : x;
      my = (o[1] && y[31]) ? -y : y;
      if (my == 0) begin q = 32'hFFFF_FFFF; r = mx; end
      else begin q = mx / my; r = mx % my; end
      if (o[1] && (x[31] ^ y[31])) q = -q;
      if (o[1] && x[31]) r = -r;
      rh = r;
      rl = q;
    end
  endfunction

  // driver: waits for idle, requests, pushes the expected item
  task automatic issue(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                       input string tag);
    exp_t e;
    logic was_done;
    @(negedge clk);
    while (busy) @(negedge clk);
    was_done = done;
    start = 1'b1; op = o; a = x; b = y;
    model(o, x, y, e.hi, e.lo);
    e.cyc = cyc + 35;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    checks++;
    if (busy !== 1'b1) begin
      fails++;
      $display("FAIL %s busy after accept actual=%b expected=1", was_done ? "R10" : "R6", busy);
    end
  endtask

  // monitor: pops on every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " hi"}, hi, e.hi);
        chk({e.tag, " lo"}, lo, e.lo);
        chk("R6 latency", 32'(cyc), 32'(e.cyc));
        last_hi = hi;
        last_lo = lo;
      end
    end
  end

  task automatic drain();
    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 hi", hi, 32'd0);
    chk("R1 lo", lo, 32'd0);
    rst_n = 1'b1;

    // R2 unsigned multiply
    issue(2'b00, 32'd12345, 32'd6789, "R2");
    issue(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    issue(2'b00, 32'h8000_0000, 32'd2, "R2");
    issue(2'b00, 32'd0, 32'hDEAD_BEEF, "R2");
    // R3 signed multiply
    issue(2'b10, -32'sd3, 32'd5, "R3");
    issue(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    issue(2'b10, 32'h8000_0000, 32'h8000_0000, "R3");
    issue(2'b10, 32'h7FFF_FFFF, 32'h8000_0000, "R3");
    // R4 unsigned divide
    issue(2'b01, 32'd100, 32'd7, "R4");
    issue(2'b01, 32'hFFFF_FFFF, 32'd1, "R4");
    issue(2'b01, 32'd5, 32'd9, "R4");
    issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R4");
    // R5 signed divide, all sign combinations
    issue(2'b11, -32'sd7, 32'd2, "R5");
    issue(2'b11, 32'd7, -32'sd2, "R5");
    issue(2'b11, -32'sd7, -32'sd2, "R5");
    issue(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, "R5");
    // R9 divide by zero
    issue(2'b01, 32'h1234_5678, 32'd0, "R9");
    issue(2'b11, -32'sd9, 32'd0, "R9");
    issue(2'b11, 32'd9, 32'd0, "R9");
    drain();

    // R7 start ignored while busy; R8 results hold mid-operation
    issue(2'b00, 32'd1000, 32'd3000, "R7");
    repeat (5) @(negedge clk);
    start = 1'b1; op = 2'b11; a = 32'hCAFE_0001; b = 32'd3;
    repeat (4) @(negedge clk);
    start = 1'b0;
    chk("R8 hi hold", hi, last_hi);
    chk("R8 lo hold", lo, last_lo);
    repeat (10) @(negedge clk);
    chk("R8 hi hold", hi, last_hi);
    drain();
    chk("R7 no extra done", 32'(done), 32'd0);
    chk("R7 idle", 32'(busy), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule